// File: doc/BRIEF.md
# GPIO Bank with Edge-Detect Interrupts

This block is one bank of general-purpose pins on a simple register bus. Software reads the live pin levels. It sets each pin's direction, and it changes the output latch only through atomic set and clear words. A read-modify-write of the latch is never needed, so two agents cannot corrupt each other's pins.

Every pad input passes through a synchroniser. Each pin can arm a rising-edge detector, a falling-edge detector, both, or neither. An armed edge sets a sticky status bit. The single interrupt line stays asserted while any status bit is set. Software clears status bits by writing ones to them.

The bus is single-cycle. Writes take effect on the clock edge where the write enable is high. Read data is a combinational function of the address.

Top module: `gpio_edge_bank`

## Requirements
- R1: A write to word offset 2 sets to 1 every output-latch bit whose write-data bit is 1. Latch bits written as 0 keep their value. The latch drives `pad_out` from the next cycle.
- R2: A write to word offset 3 clears to 0 every output-latch bit whose write-data bit is 1. Latch bits written as 0 keep their value.
- R3: A read of offset 0 returns the pad input levels as seen through a two-flop synchroniser. A pad change appears in the read data after two rising clock edges, and not after only one.
- R4: Offset 1 is the read/write direction register. A bit of 1 makes the pin an output: `pad_oe` follows the register. A bit of 0 makes the pin an input.
- R5: The output latch keeps its value while the pin is an input, so software can preset a level before turning the pin to output. Reads of offset 2 or offset 3 return the latch.
- R6: Offset 4 is the read/write rising-enable register. With its bit set, a 0-to-1 change of the synchronised pin sets that pin's status bit. A 1-to-0 change does not set the bit unless the pin's falling enable is also set.
- R7: Offset 5 is the read/write falling-enable register. With its bit set, a 1-to-0 change sets the status bit. A pin with both enables set flags both directions. A pin with neither enable set never flags.
- R8: Offset 6 is the sticky edge-status register. Writing 1 to a bit clears it. Writing 0 leaves the bit unchanged.
- R9: If an armed edge is detected in the same cycle as a write-one-to-clear of that status bit, the bit stays set.
- R10: `irq_o` is high exactly while any status bit is set. It stays high until every set bit has been cleared.
- R11: With `NUM_PINS` below 32, the register bits above the pin count read as zero, ignore writes, and never flag.
- R12: After reset, the latch, direction, both enables and status are all zero, so every pin is an input and `irq_o` is low. Offset 7 reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Word offset of the register |
| bus_we | input | 1 | Write enable, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NUM_PINS | Pad input levels, asynchronous |
| pad_out | output | NUM_PINS | Output latch driven toward the pads |
| pad_oe | output | NUM_PINS | Per-pin output enable, from the direction register |
| irq_o | output | 1 | Combined edge interrupt |

## Verification
The bench builds the bank with `NUM_PINS` set to 20 rather than the full 32. This puts twelve unimplemented bit positions on every register. Writing all ones to the direction and enable registers, and toggling every pad at once, then shows that those positions read as zero and never raise a status bit. All other behaviour is checked on the 20 live pins. This covers the set/clear latch, the synchroniser latency, each enable combination, the write-one-to-clear rules, and a clear that collides with a fresh edge in the same cycle.

// File: rtl/gpio_edge_pkg.sv
// Package: shared bus widths and the register offset encoding of the bank.
// Assumes a 32-bit data bus and eight word offsets.
package gpio_edge_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        OFS_LEVEL  = 3'd0,
        OFS_DIR    = 3'd1,
        OFS_SET    = 3'd2,
        OFS_CLR    = 3'd3,
        OFS_RISE   = 3'd4,
        OFS_FALL   = 3'd5,
        OFS_STATUS = 3'd6,
        OFS_NONE   = 3'd7
    } gpio_ofs_e;
endpackage

// File: rtl/gpio_sync_chain.sv
// Module: multi-stage synchroniser for a vector of asynchronous pad inputs.
// Assumes the bits are independent; there is no coherence between bits.
module gpio_sync_chain #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // One flop stage of the chain; stage 0 samples the pads.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage_q[s] <= '0;
                else if (s == 0)
                    stage_q[s] <= async_in;
                else
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_status.sv
// Module: per-pin edge detection and the sticky status register.
// Assumes lvl is already synchronous to clk. A fresh edge wins over a
// clear of the same bit in the same cycle.
module gpio_edge_status #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    input  logic [WIDTH-1:0] rise_en,
    input  logic [WIDTH-1:0] fall_en,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] status
);
    logic [WIDTH-1:0] lvl_prev;
    logic [WIDTH-1:0] hit;

    // Remember last cycle's level so that changes can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_prev <= '0;
        else        lvl_prev <= lvl;
    end

    // Armed edges this cycle: rising or falling, filtered by the enables.
    always_comb begin
        hit = (lvl & ~lvl_prev & rise_en) | (~lvl & lvl_prev & fall_en);
    end

    // Sticky flags: clear by mask, then let new edges set (edge wins).
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_mask) | hit;
    end
endmodule

// File: rtl/gpio_ctrl_regs.sv
// Module: bus write decode and the software-owned control state.
// Holds the output latch, direction and edge enables. It also turns a write
// of the status offset into a one-cycle clear mask. Assumes write data
// has already been cut to the pin count.
module gpio_ctrl_regs
    import gpio_edge_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_en,
    input  logic [WIDTH-1:0]  wr_bits,
    output logic [WIDTH-1:0]  out_latch,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  rise_q,
    output logic [WIDTH-1:0]  fall_q,
    output logic [WIDTH-1:0]  clr_mask
);
    gpio_ofs_e ofs;
    assign ofs = gpio_ofs_e'(wr_addr);

    // Output latch: changed only through the atomic set and clear words.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_latch <= '0;
        else if (wr_en && ofs == OFS_SET)
            out_latch <= out_latch | wr_bits;
        else if (wr_en && ofs == OFS_CLR)
            out_latch <= out_latch & ~wr_bits;
    end

    // Direction and edge-enable registers: plain read/write words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
        end else if (wr_en) begin
            if (ofs == OFS_DIR)  dir_q  <= wr_bits;
            if (ofs == OFS_RISE) rise_q <= wr_bits;
            if (ofs == OFS_FALL) fall_q <= wr_bits;
        end
    end

    // Write-one-to-clear mask for the status register, live this cycle.
    always_comb begin
        clr_mask = (wr_en && ofs == OFS_STATUS) ? wr_bits : '0;
    end
endmodule

// File: rtl/gpio_edge_bank.sv
// Module: top of one GPIO bank with edge-detect interrupts.
// Wires the synchroniser, the control registers and the edge/status logic,
// and muxes read data. Assumes NUM_PINS is between 1 and 32; the unused
// upper bits read as zero.
module gpio_edge_bank
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic              irq_o
);
    logic [NUM_PINS-1:0] lvl_sync;
    logic [NUM_PINS-1:0] latch_q, dir_q, rise_q, fall_q, clr_mask, status_q;
    logic [NUM_PINS-1:0] wr_bits;

    assign wr_bits = bus_wdata[NUM_PINS-1:0];

    gpio_sync_chain #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (lvl_sync)
    );

    gpio_ctrl_regs #(.WIDTH(NUM_PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_addr   (bus_addr),
        .wr_en     (bus_we),
        .wr_bits   (wr_bits),
        .out_latch (latch_q),
        .dir_q     (dir_q),
        .rise_q    (rise_q),
        .fall_q    (fall_q),
        .clr_mask  (clr_mask)
    );

    gpio_edge_status #(.WIDTH(NUM_PINS)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (lvl_sync),
        .rise_en  (rise_q),
        .fall_en  (fall_q),
        .clr_mask (clr_mask),
        .status   (status_q)
    );

    assign pad_out = latch_q;
    assign pad_oe  = dir_q;
    assign irq_o   = |status_q;

    // Read mux, zero-extended to the bus width.
    always_comb begin
        unique case (gpio_ofs_e'(bus_addr))
            OFS_LEVEL:         bus_rdata = BUS_W'(lvl_sync);
            OFS_DIR:           bus_rdata = BUS_W'(dir_q);
            OFS_SET, OFS_CLR:  bus_rdata = BUS_W'(latch_q);
            OFS_RISE:          bus_rdata = BUS_W'(rise_q);
            OFS_FALL:          bus_rdata = BUS_W'(fall_q);
            OFS_STATUS:        bus_rdata = BUS_W'(status_q);
            default:           bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_edge_bank_chk.sv
// Checker: port-level properties of the GPIO bank, bound to the top module.
// Assumes it sees the top's ports unchanged.
module gpio_edge_bank_chk
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic [BUS_W-1:0]    bus_wdata,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic                irq_o
);
    logic [NUM_PINS-1:0] wbits;
    assign wbits = bus_wdata[NUM_PINS-1:0];

    p_set_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_SET) |=>
            (pad_out == ($past(pad_out) | $past(wbits))));

    p_clr_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_CLR) |=>
            (pad_out == ($past(pad_out) & ~$past(wbits))));

    p_dir_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_DIR) |=> (pad_oe == $past(wbits)));

    p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && (bus_addr == OFS_SET || bus_addr == OFS_CLR)) |=>
            $stable(pad_out));

    p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(bus_we && bus_addr == OFS_STATUS)) |=> irq_o);

    p_reset_state_r12: assert property (@(posedge clk)
        !rst_n |=> (pad_out == '0 && pad_oe == '0 && !irq_o));
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq_o     (irq_o)
);

// File: tb/gpio_edge_bank_tb.sv
// Directed bench for the GPIO bank, built with 20 pins.
module gpio_edge_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 20;
    localparam logic [31:0] PMASK = 32'h000F_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe;
    logic        irq_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_edge_bank #(.NUM_PINS(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(3'd1, d); check("R12 dir after reset", d, 0);
        rd(3'd6, d); check("R12 status after reset", d, 0);
        rd(3'd2, d); check("R12 latch after reset", d, 0);
        rd(3'd7, d); check("R12 offset 7 reads zero", d, 0);
        check("R12 pad_oe after reset", 32'(pad_oe), 0);
        check("R12 irq after reset", 32'(irq_o), 0);
    endtask

    task automatic t_set_clear();
        logic [31:0] d;
        wr(3'd2, 32'h0000_00A5); #1 check("R1 set a5", 32'(pad_out), 32'hA5);
        wr(3'd2, 32'h0000_0100); #1 check("R1 set keeps others", 32'(pad_out), 32'h1A5);
        wr(3'd3, 32'h0000_0005); #1 check("R2 clear bits", 32'(pad_out), 32'h1A0);
        rd(3'd3, d); check("R5 latch read via offset 3", d, 32'h1A0);
        check("R5 pins still inputs", 32'(pad_oe), 0);
    endtask

    task automatic t_direction();
        logic [31:0] d;
        wr(3'd1, 32'h0000_00F0); #1 check("R4 pad_oe follows dir", 32'(pad_oe), 32'hF0);
        rd(3'd1, d); check("R4 dir readback", d, 32'hF0);
        rd(3'd2, d); check("R5 latch held across dir change", d, 32'h1A0);
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, d); check("R11 dir upper bits read zero", d, PMASK);
        wr(3'd1, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        @(negedge clk); pad_in = 20'h5_A5A5;
        @(negedge clk); #1 d = 32'(u_dut.bus_rdata); // placeholder ignored
        bus_addr = 3'd0; #1 d = bus_rdata;
        check("R3 level not yet after one edge", d, 0);
        @(negedge clk); #1 d = bus_rdata;
        check("R3 level after two edges", d, 32'h5_A5A5);
        @(negedge clk); pad_in = '0;
        settle();
    endtask

    task automatic t_edges();
        logic [31:0] d;
        wr(3'd4, 32'h0000_0005);  // rise on pins 0 and 2
        wr(3'd5, 32'h0000_0006);  // fall on pins 1 and 2
        @(negedge clk); pad_in[3:0] = 4'hF; settle();
        rd(3'd6, d); check("R6 R7 rising edges flag pins 0 and 2", d, 32'h5);
        check("R10 irq high", 32'(irq_o), 1);
        wr(3'd6, 32'h0); rd(3'd6, d); check("R8 write zero no effect", d, 32'h5);
        wr(3'd6, 32'h5); rd(3'd6, d); check("R8 write one clears", d, 0);
        #1 check("R10 irq low after clearing all", 32'(irq_o), 0);
        @(negedge clk); pad_in[3:0] = 4'h0; settle();
        rd(3'd6, d); check("R7 falling edges flag pins 1 and 2, not 0 or 3", d, 32'h6);
        wr(3'd6, 32'h2); rd(3'd6, d); check("R10 one bit still set", d, 32'h4);
        check("R10 irq stays high", 32'(irq_o), 1);
        wr(3'd6, 32'h4); #1 check("R10 irq drops", 32'(irq_o), 0);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        wr(3'd4, 32'h0000_0020);
        wr(3'd5, 32'h0000_0020);
        @(negedge clk); pad_in[5] = 1'b1; settle();
        rd(3'd6, d); check("R6 pin 5 rising", d, 32'h20);
        @(negedge clk); pad_in[5] = 1'b0;
        @(negedge clk);
        wr(3'd6, 32'h20);   // clear lands in the cycle the fall is seen
        rd(3'd6, d); check("R9 edge wins over clear", d, 32'h20);
        wr(3'd6, 32'h20); rd(3'd6, d); check("R9 plain clear afterwards", d, 0);
    endtask

    task automatic t_unused();
        logic [31:0] d;
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd4, d); check("R11 rise enable upper zero", d, PMASK);
        @(negedge clk); pad_in = '1; settle();
        @(negedge clk); pad_in = '0; settle();
        rd(3'd6, d); check("R11 only live pins flag", d, PMASK);
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd6, d); check("R11 status cleared", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_set_clear();
        t_direction();
        t_level();
        t_edges();
        t_collision();
        t_unused();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule